// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers twelve event sources into a sticky 16-bit status word and drives a single level-sensitive interrupt line toward a host processor. Each source is a one-cycle set pulse that latches its status bit. One source also has a second trigger: a power-button level input whose low-to-high transition sets the push-button status bit. The host reaches the block through a small byte-wide register port with a combinational read. That port exposes a 16-bit mask as two bytes, the status word as two read-only bytes, and two write-only acknowledge bytes. Writing a one to an acknowledge bit clears the matching status bit.

Masking only gates the interrupt output. A masked source still latches, so the host can poll it. After reset every source is masked and the status word is empty, so the line stays low until software opens the mask.

The register port is plain control: a write strobe, an address, write data and read data. It has no handshake. Every access completes in one cycle, and it never applies back-pressure.

Top module: `isc_irq_ctrl`

## Requirements
- R1: `irq_o` is high exactly when some status bit is set whose mask bit is clear, evaluated from the registered status and mask.
- R2: After reset the mask reads 0x0FFF (low byte 0xFF, high byte 0x0F), both status bytes read 0x00 and `irq_o` is low.
- R3: A write to address 4 (acknowledge-low) clears each status bit [7:0] whose data bit is one; a write to address 5 (acknowledge-high) does the same for bits [15:8]; zero data bits and the other byte are left untouched.
- R4: Reads of addresses 4 and 5 return 0x00. Status addresses 2 (bits [7:0]) and 3 (bits [15:8]) are read-only, and writes to them change nothing.
- R5: A write to address 0 replaces only mask bits [7:0]; a write to address 1 replaces only mask bits [15:8]; `irq_o` reflects the new mask from the clock edge that performs the write.
- R6: A pulse on `evt_set_i[i]` sets status bit i at the next clock edge. Bit 8 is the periodic timer event, bit 9 the alarm, bit 10 the clock-update error and bit 11 the push-button event. Status bits [15:12] always read zero.
- R7: Status bit 11 is set at the first clock edge that samples `btn_i` high after a sample of it low (the previous sample is taken as low at reset). Holding `btn_i` high never sets it again.
- R8: When a set and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R9: A status bit whose mask bit is set still latches its event and reads back through its status address.
- R10: Addresses 6 and 7 read 0x00 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Read data for `addr_i`, combinational |
| evt_set_i | input | 12 | One-cycle set pulses, one per status bit |
| btn_i | input | 1 | Power-button level; a rising edge raises bit 11 |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench acknowledges a bit in the same cycle that its source pulses. A design that gives the acknowledge priority would lose that event and read the bit back as zero. It holds the button high across an acknowledge of bit 11, which catches a level-triggered design because the bit would come straight back. It writes each mask byte alone and rereads the other byte, which exposes a full-word write or a swapped byte lane. It also writes into the status and acknowledge addresses and checks that status cannot be set through software and that acknowledge reads as zero. Finally, it confirms that masked events still latch while the line stays low, so a design that gates the latch with the mask instead of the output would read back zero.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int NUM_BYTES = WORD_W / BYTE_W;
  localparam int ADDR_W    = 3;
  // register map: each group is NUM_BYTES consecutive byte lanes, low lane first
  localparam int MASK_BASE = 0;
  localparam int STAT_BASE = 2;
  localparam int ACK_BASE  = 4;
  // named status bit positions
  localparam int BIT_TICK   = 8;
  localparam int BIT_ALARM  = 9;
  localparam int BIT_UPDERR = 10;
  localparam int BIT_BUTTON = 11;
endpackage

// File: rtl/isc_edge_detect.sv
module isc_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int NUM_SRC = 12,
  localparam int NUM_BYTES = WORD_W / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BYTES-1:0] we_i,
  input  logic [BYTE_W-1:0]    data_i,
  output logic [WORD_W-1:0]    mask_o
);
  localparam logic [WORD_W-1:0] RST_VAL = WORD_W'((1 << NUM_SRC) - 1);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)        mask_o[b*BYTE_W +: BYTE_W] <= RST_VAL[b*BYTE_W +: BYTE_W];
      else if (we_i[b]) mask_o[b*BYTE_W +: BYTE_W] <= data_i;
    end

    AST_MASK_LANE_LOAD: assert property (@(posedge clk) disable iff (rst)
      we_i[b] |=> mask_o[b*BYTE_W +: BYTE_W] == $past(data_i)); // R5
    AST_MASK_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !we_i[b] |=> $stable(mask_o[b*BYTE_W +: BYTE_W])); // R5
  end
endmodule

// File: rtl/isc_status_bank.sv
module isc_status_bank #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int NUM_SRC = 12,
  localparam int NUM_BYTES = WORD_W / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   set_i,
  input  logic [NUM_BYTES-1:0] ack_we_i,
  input  logic [BYTE_W-1:0]    data_i,
  output logic [WORD_W-1:0]    stat_o
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i < NUM_SRC) begin : g_live
      logic ack_hit;
      assign ack_hit = ack_we_i[i / BYTE_W] & data_i[i % BYTE_W];

      // a set pulse outranks a same-cycle acknowledge
      always_ff @(posedge clk) begin
        if (rst)          stat_o[i] <= 1'b0;
        else if (set_i[i]) stat_o[i] <= 1'b1;
        else if (ack_hit) stat_o[i] <= 1'b0;
      end

      AST_SET_LATCHES: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> stat_o[i]); // R8
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !set_i[i]) |=> !stat_o[i]); // R3
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_o[i] && !ack_hit) |=> stat_o[i]); // R9
    end else begin : g_tie
      assign stat_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/isc_reg_read.sv
module isc_reg_read
  import isc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  localparam int NUM_BYTES = WORD_W / BYTE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  // acknowledge and unused addresses fall through to zero
  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (addr_i == ADDR_W'(MASK_BASE + b)) rd_data_o = mask_i[b*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(STAT_BASE + b)) rd_data_o = stat_i[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/isc_irq_ctrl.sv
module isc_irq_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  output logic [BYTE_W-1:0]  rd_data_o,
  input  logic [NUM_SRC-1:0] evt_set_i,
  input  logic               btn_i,
  output logic               irq_o
);
  logic [NUM_BYTES-1:0] mask_we, ack_we;
  logic [WORD_W-1:0]    mask_q, stat_q;
  logic [NUM_SRC-1:0]   set_vec;
  logic                 btn_rise;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_dec
    assign mask_we[b] = wr_en_i && (addr_i == ADDR_W'(MASK_BASE + b));
    assign ack_we[b]  = wr_en_i && (addr_i == ADDR_W'(ACK_BASE + b));
  end

  isc_edge_detect u_btn (
    .clk(clk), .rst(rst), .lvl_i(btn_i), .rise_o(btn_rise)
  );

  always_comb begin
    set_vec = evt_set_i;
    set_vec[BIT_BUTTON] = evt_set_i[BIT_BUTTON] | btn_rise;
  end

  isc_mask_reg #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .we_i(mask_we), .data_i(wr_data_i), .mask_o(mask_q)
  );

  isc_status_bank #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst(rst), .set_i(set_vec), .ack_we_i(ack_we),
    .data_i(wr_data_i), .stat_o(stat_q)
  );

  isc_reg_read #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rd (
    .addr_i(addr_i), .mask_i(mask_q), .stat_i(stat_q), .rd_data_o(rd_data_o)
  );

  assign irq_o = |(stat_q & ~mask_q);

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask_q[NUM_SRC-1:0]) |-> !irq_o); // R1
  AST_BUTTON_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[BIT_BUTTON]) |-> $past(evt_set_i[BIT_BUTTON] || btn_rise)); // R7
  AST_UNMASKED_FIRES: assert property (@(posedge clk) disable iff (rst)
    (evt_set_i[0] && !mask_q[0] && !mask_we[0]) |=> irq_o); // R1
endmodule

// File: tb/tb_isc_irq_ctrl.sv
module tb_isc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [11:0] evt = '0;
  logic       btn = 1'b0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  isc_irq_ctrl dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .evt_set_i(evt), .btn_i(btn), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic [11:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    rd_chk("R2 mask lo", 3'd0, 8'hFF);
    rd_chk("R2 mask hi", 3'd1, 8'h0F);
    rd_chk("R2 stat lo", 3'd2, 8'h00);
    rd_chk("R2 stat hi", 3'd3, 8'h00);
    chk("R2 irq", irq, 0);
  endtask

  task automatic t_masked_latch;
    pulse(12'h005);
    rd_chk("R9 masked bits latch", 3'd2, 8'h05);
    chk("R9 irq stays low", irq, 0);
  endtask

  task automatic t_irq;
    wr(3'd0, 8'hFE);
    chk("R1 irq after unmask bit0", irq, 1);
    wr(3'd0, 8'hFB);
    chk("R5 irq with bit2 unmasked", irq, 1);
    wr(3'd0, 8'hFF);
    chk("R1 irq after remask", irq, 0);
  endtask

  task automatic t_mask_bytes;
    wr(3'd1, 8'hA5);
    rd_chk("R5 mask hi loaded", 3'd1, 8'hA5);
    rd_chk("R5 mask lo untouched", 3'd0, 8'hFF);
    wr(3'd0, 8'h3C);
    rd_chk("R5 mask lo loaded", 3'd0, 8'h3C);
    rd_chk("R5 mask hi untouched", 3'd1, 8'hA5);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h0F);
  endtask

  task automatic t_ack;
    pulse(12'h300);
    rd_chk("R6 tick+alarm", 3'd3, 8'h03);
    wr(3'd4, 8'h01);
    rd_chk("R3 ack lo clears bit0", 3'd2, 8'h04);
    rd_chk("R3 ack lo spares hi", 3'd3, 8'h03);
    wr(3'd5, 8'h01);
    rd_chk("R3 ack hi clears bit8", 3'd3, 8'h02);
    rd_chk("R3 ack hi spares lo", 3'd2, 8'h04);
    rd_chk("R4 ack lo reads zero", 3'd4, 8'h00);
    rd_chk("R4 ack hi reads zero", 3'd5, 8'h00);
    wr(3'd3, 8'h00);
    rd_chk("R4 stat hi read-only", 3'd3, 8'h02);
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    rd_chk("R3 all clear lo", 3'd2, 8'h00);
    rd_chk("R3 all clear hi", 3'd3, 8'h00);
    wr(3'd2, 8'hFF);
    rd_chk("R4 stat lo write ignored", 3'd2, 8'h00);
  endtask

  task automatic t_sources;
    pulse(12'h400);
    rd_chk("R6 update error is bit10", 3'd3, 8'h04);
    pulse(12'hF00);
    rd_chk("R6 upper bits zero", 3'd3, 8'h0F);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd_chk("R10 addr6 zero", 3'd6, 8'h00);
    rd_chk("R10 addr7 zero", 3'd7, 8'h00);
    rd_chk("R10 mask hi intact", 3'd1, 8'h0F);
    rd_chk("R10 stat lo intact", 3'd2, 8'h00);
  endtask

  task automatic t_button;
    wr(3'd1, 8'h07);
    @(negedge clk); btn = 1'b1;
    @(negedge clk);
    rd_chk("R7 rise sets bit11", 3'd3, 8'h08);
    chk("R1 irq on unmasked button", irq, 1);
    wr(3'd5, 8'h08);
    repeat (3) @(negedge clk);
    rd_chk("R7 held high no re-raise", 3'd3, 8'h00);
    chk("R1 irq low after ack", irq, 0);
    @(negedge clk); btn = 1'b0;
    @(negedge clk); btn = 1'b1;
    @(negedge clk);
    rd_chk("R7 second rise", 3'd3, 8'h08);
    wr(3'd5, 8'h08);
    wr(3'd1, 8'h0F);
    @(negedge clk); btn = 1'b0;
  endtask

  task automatic t_set_wins;
    pulse(12'h001);
    @(negedge clk); addr = 3'd4; wdata = 8'h03; wr_en = 1'b1; evt = 12'h002;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    rd_chk("R8 set beats ack", 3'd2, 8'h02);
    wr(3'd4, 8'h02);
    rd_chk("R8 later ack clears", 3'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masked_latch();
    t_irq();
    t_mask_bytes();
    t_ack();
    t_sources();
    t_button();
    t_set_wins();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule